// File: doc/BRIEF.md
# Coalescing Retire Group Queue

This block sits at the back end of an out-of-order core. It takes the in-order stream of decoded operations (uops) and packs neighbours into retire groups. Each group holds at most seven uops and at most `MAX_ISSUE` uops that occupy an execution unit. Eliminated uops, which never issue, can fill the remaining places. Two uop classes constrain placement. A uop that can fault before it retires always opens a fresh group. A uop that can fail after it retires always ends its group.

Groups wait in a circular queue of `QDEPTH` entries until every uop in them has reported completion. Completion arrives on a writeback port that names the group tag and the slot inside the group. Complete groups leave in order, oldest first, up to `RET_W` per cycle. A companion counter tracks architectural register writes. It admits new writes up to `REN_CAP` outstanding, and releases the writes of retired groups at no more than `REN_REL` per cycle. A flush drops every unretired group and rolls the write count back to the retired point.

Top module: `retire_group_queue`

## Requirements
- R1: After reset the queue is empty and `q_full`, `ret_groups` and `ren_release` are 0. The first uop gets tag 0 and slot 0.
- R2: Uops join the open group in arrival order and get slots 0 to 6. A uop that arrives when the open group already holds 7 uops opens a new group at slot 0.
- R3: A uop with `alloc_fault_first` set always gets slot 0 of a new group. The previous open group closes.
- R4: A uop with `alloc_fail_last` set closes its group. The next uop gets slot 0 of a new group.
- R5: A uop with `alloc_issue` set opens a new group when the open group already holds `MAX_ISSUE` issuing uops. Uops with `alloc_issue` clear do not count toward that limit.
- R6: A group retires only when all of the following hold: it is closed, every allocated slot has completed, and every older group has retired. At most `RET_W` groups retire per clock edge. `ret_groups` shows the number retired at the previous edge.
- R7: An open group closes when it meets both conditions: all of its uops have completed, and `alloc_valid` is low for a cycle. After that it can retire.
- R8: `q_full` is 1 when `QDEPTH` groups are held. In that state, a uop that needs a new group is stalled (`alloc_stall`=1). A uop that joins the open group is accepted.
- R9: A uop is stalled when the outstanding register writes plus its `alloc_writes` would exceed `REN_CAP`.
- R10: The writes of retired groups are released at most `REN_REL` per cycle. The count released at an edge appears on `ren_release` after that edge.
- R11: `flush` discards all unretired groups and any open group. It ignores that cycle's allocation and completion and retires nothing at that edge. It subtracts the discarded groups' writes from the outstanding count. New groups resume at the oldest discarded tag.
- R12: Group tags are handed out in sequence and wrap modulo `QDEPTH`. `alloc_tag` and `alloc_slot` show the place the presented uop takes if it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | A uop is presented for allocation |
| alloc_fault_first | input | 1 | The uop may fault before retiring |
| alloc_fail_last | input | 1 | The uop may fail after retiring |
| alloc_issue | input | 1 | The uop occupies an execution unit |
| alloc_writes | input | 2 | Architectural register writes made by the uop |
| alloc_stall | output | 1 | The presented uop is not accepted this cycle |
| alloc_tag | output | TAG_W | Group tag the uop is placed in |
| alloc_slot | output | 3 | Slot within that group |
| cpl_valid | input | 1 | A uop completion is reported |
| cpl_tag | input | TAG_W | Group tag of the completing uop |
| cpl_slot | input | 3 | Slot of the completing uop |
| flush | input | 1 | Discard all unretired groups |
| q_full | output | 1 | All group entries are in use |
| ret_groups | output | RC_W | Groups retired at the previous edge |
| ren_release | output | REL_W | Register writes released at the previous edge |

## Verification
The bench builds the block with `QDEPTH`=5, `RET_W`=2, `REN_CAP`=12 and `REN_REL`=3. At these sizes a handful of fault-first uops fills the queue, and tags wrap every five groups. Six uops with two writes each reach the write limit inside a single group. Bursts of completed groups expose both the two-per-edge retire cap and the three-per-edge release cap. Long random runs with occasional flushes reach every one of these states many times.

// File: rtl/rgq_pkg.sv
package rgq_pkg;
  localparam int UOP_SLOTS = 7;
  localparam int SLOT_W    = 3;
  localparam int UW_W      = 2;
  localparam int GWR_W     = 5;
  typedef logic [UOP_SLOTS-1:0] umask_t;
  typedef logic [SLOT_W-1:0]    slot_t;
endpackage

// File: rtl/rgq_place.sv
module rgq_place
  import rgq_pkg::*;
#(
  parameter int MAX_ISSUE = 4
) (
  input  logic  open_v,
  input  slot_t open_cnt,
  input  slot_t open_iss,
  input  logic  fault_first,
  input  logic  issue,
  output logic  need_new
);
  always_comb begin
    need_new = !open_v
            || fault_first
            || (open_cnt == slot_t'(UOP_SLOTS))
            || (issue && (32'(open_iss) >= MAX_ISSUE));
  end
endmodule

// File: rtl/rgq_scan.sv
module rgq_scan #(
  parameter int RET_W = 8,
  parameter int GWR_W = 5,
  parameter int SUM_W = 9,
  parameter int RC_W  = 4
) (
  input  logic [RET_W-1:0]       elig,
  input  logic [RET_W*GWR_W-1:0] gw_flat,
  output logic [RC_W-1:0]        nret,
  output logic [SUM_W-1:0]       wsum
);
  always_comb begin
    logic run;
    run  = 1'b1;
    nret = '0;
    wsum = '0;
    for (int k = 0; k < RET_W; k++) begin
      if (run && elig[k]) begin
        nret = nret + RC_W'(1);
        wsum = wsum + SUM_W'(gw_flat[k*GWR_W +: GWR_W]);
      end else begin
        run = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rgq_rename.sv
module rgq_rename #(
  parameter int CAP   = 623,
  parameter int REL   = 16,
  parameter int AW    = 2,
  parameter int SUM_W = 9,
  localparam int REN_W = $clog2(CAP + 1),
  localparam int REL_W = $clog2(REL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [AW-1:0]    add_w,
  input  logic [SUM_W-1:0] ret_w,
  output logic [REN_W-1:0] used,
  output logic [REL_W-1:0] release_q
);
  logic [REN_W-1:0] used_q, pend_q, spec_q, rel, retn, addn;

  assign retn = REN_W'(ret_w);
  assign addn = REN_W'(add_w);
  assign rel  = (32'(pend_q) < REL) ? pend_q : REN_W'(REL);
  assign used = used_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q    <= '0;
      pend_q    <= '0;
      spec_q    <= '0;
      release_q <= '0;
    end else begin
      pend_q    <= pend_q - rel + retn;
      release_q <= REL_W'(rel);
      if (flush) begin
        used_q <= used_q - rel - spec_q;
        spec_q <= '0;
      end else begin
        used_q <= used_q - rel + addn;
        spec_q <= spec_q + addn - retn;
      end
    end
  end
endmodule

// File: rtl/retire_group_queue.sv
module retire_group_queue
  import rgq_pkg::*;
#(
  parameter int QDEPTH    = 330,
  parameter int RET_W     = 8,
  parameter int MAX_ISSUE = 4,
  parameter int REN_CAP   = 623,
  parameter int REN_REL   = 16,
  localparam int TAG_W = $clog2(QDEPTH),
  localparam int RC_W  = $clog2(RET_W + 1),
  localparam int REL_W = $clog2(REN_REL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_valid,
  input  logic             alloc_fault_first,
  input  logic             alloc_fail_last,
  input  logic             alloc_issue,
  input  logic [1:0]       alloc_writes,
  output logic             alloc_stall,
  output logic [TAG_W-1:0] alloc_tag,
  output logic [2:0]       alloc_slot,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic [2:0]       cpl_slot,
  input  logic             flush,
  output logic             q_full,
  output logic [RC_W-1:0]  ret_groups,
  output logic [REL_W-1:0] ren_release
);
  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam int REN_W = $clog2(REN_CAP + 1);
  localparam int SUM_W = GWR_W + $clog2(RET_W) + 1;

  function automatic logic [TAG_W-1:0] tag_add(input logic [TAG_W-1:0] base, input int unsigned k);
    int unsigned s;
    s = 32'(base) + k;
    if (s >= QDEPTH) s = s - QDEPTH;
    return TAG_W'(s);
  endfunction

  // group storage, one entry per tag
  umask_t           vmask_q  [QDEPTH];
  umask_t           dmask_q  [QDEPTH];
  logic             closed_q [QDEPTH];
  logic [GWR_W-1:0] gwr_q    [QDEPTH];

  logic [TAG_W-1:0] head_q, tail_q, open_tag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             open_q;
  slot_t            ocnt_q, oiss_q;
  logic [RC_W-1:0]  ret_q;

  logic             need_new, ren_block, acc, idle_close;
  logic [REN_W-1:0] ren_used;
  logic [RC_W-1:0]  nret, nret_eff;
  logic [SUM_W-1:0] wsum, wsum_eff;
  logic [1:0]       add_w;
  logic [RET_W-1:0] elig;
  logic [RET_W*GWR_W-1:0] gw_flat;
  logic [TAG_W-1:0] win_idx [RET_W];

  rgq_place #(.MAX_ISSUE(MAX_ISSUE)) u_place (
    .open_v     (open_q),
    .open_cnt   (ocnt_q),
    .open_iss   (oiss_q),
    .fault_first(alloc_fault_first),
    .issue      (alloc_issue),
    .need_new   (need_new)
  );

  assign q_full      = (32'(cnt_q) == QDEPTH);
  assign ren_block   = (32'(ren_used) + 32'(alloc_writes)) > REN_CAP;
  assign alloc_stall = alloc_valid && ((need_new && q_full) || ren_block);
  assign acc         = alloc_valid && !alloc_stall && !flush;
  assign alloc_tag   = need_new ? tail_q : open_tag_q;
  assign alloc_slot  = need_new ? 3'd0 : ocnt_q;
  assign idle_close  = open_q && !alloc_valid && (dmask_q[open_tag_q] == vmask_q[open_tag_q]);
  assign add_w       = acc ? alloc_writes : 2'd0;

  // retire window at the head of the queue
  for (genvar k = 0; k < RET_W; k++) begin : g_win
    assign win_idx[k] = tag_add(head_q, k);
    assign elig[k]    = (32'(cnt_q) > k) && closed_q[win_idx[k]]
                        && (dmask_q[win_idx[k]] == vmask_q[win_idx[k]]);
    assign gw_flat[k*GWR_W +: GWR_W] = gwr_q[win_idx[k]];
  end

  rgq_scan #(.RET_W(RET_W), .GWR_W(GWR_W), .SUM_W(SUM_W), .RC_W(RC_W)) u_scan (
    .elig   (elig),
    .gw_flat(gw_flat),
    .nret   (nret),
    .wsum   (wsum)
  );

  assign nret_eff = flush ? '0 : nret;
  assign wsum_eff = flush ? '0 : wsum;

  rgq_rename #(.CAP(REN_CAP), .REL(REN_REL), .AW(2), .SUM_W(SUM_W)) u_ren (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .add_w    (add_w),
    .ret_w    (wsum_eff),
    .used     (ren_used),
    .release_q(ren_release)
  );

  // entry storage: no reset, every field written when a group is opened
  always_ff @(posedge clk) begin
    if (!flush) begin
      if (cpl_valid) dmask_q[cpl_tag][cpl_slot] <= 1'b1;
      if (idle_close) closed_q[open_tag_q] <= 1'b1;
      if (acc) begin
        if (need_new) begin
          if (open_q) closed_q[open_tag_q] <= 1'b1;
          vmask_q[tail_q]  <= umask_t'(1);
          dmask_q[tail_q]  <= '0;
          closed_q[tail_q] <= alloc_fail_last;
          gwr_q[tail_q]    <= GWR_W'(alloc_writes);
        end else begin
          vmask_q[open_tag_q][ocnt_q] <= 1'b1;
          gwr_q[open_tag_q] <= gwr_q[open_tag_q] + GWR_W'(alloc_writes);
          if (alloc_fail_last) closed_q[open_tag_q] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q     <= '0;
      tail_q     <= '0;
      cnt_q      <= '0;
      open_q     <= 1'b0;
      open_tag_q <= '0;
      ocnt_q     <= '0;
      oiss_q     <= '0;
      ret_q      <= '0;
    end else if (flush) begin
      tail_q <= head_q;
      cnt_q  <= '0;
      open_q <= 1'b0;
      ret_q  <= '0;
    end else begin
      head_q <= tag_add(head_q, 32'(nret_eff));
      cnt_q  <= cnt_q - CNT_W'(nret_eff) + CNT_W'(acc && need_new);
      ret_q  <= nret_eff;
      if (acc) begin
        if (need_new) begin
          tail_q     <= tag_add(tail_q, 1);
          open_tag_q <= tail_q;
          open_q     <= !alloc_fail_last;
          ocnt_q     <= slot_t'(1);
          oiss_q     <= slot_t'(alloc_issue);
        end else begin
          ocnt_q <= ocnt_q + slot_t'(1);
          oiss_q <= oiss_q + slot_t'(alloc_issue);
          if (alloc_fail_last) open_q <= 1'b0;
        end
      end else if (idle_close) begin
        open_q <= 1'b0;
      end
    end
  end

  assign ret_groups = ret_q;
endmodule

// File: rtl/rgq_checker.sv
module rgq_checker #(
  parameter int QDEPTH  = 330,
  parameter int RET_W   = 8,
  parameter int REN_CAP = 623,
  parameter int REN_REL = 16,
  parameter int CNT_W   = 9,
  parameter int REN_W   = 10,
  parameter int RC_W    = 4,
  parameter int REL_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             alloc_valid,
  input logic             alloc_stall,
  input logic             q_full,
  input logic [2:0]       alloc_slot,
  input logic [RC_W-1:0]  ret_groups,
  input logic [REL_W-1:0] ren_release,
  input logic [CNT_W-1:0] cnt,
  input logic [REN_W-1:0] ren_used
);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) <= QDEPTH);
  a_r9_ren_bound: assert property (@(posedge clk) disable iff (rst)
    32'(ren_used) <= REN_CAP);
  a_r6_ret_width: assert property (@(posedge clk) disable iff (rst)
    32'(ret_groups) <= RET_W);
  a_r10_rel_rate: assert property (@(posedge clk) disable iff (rst)
    32'(ren_release) <= REN_REL);
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0) && (ret_groups == '0));
  a_r2_slot_range: assert property (@(posedge clk) disable iff (rst)
    alloc_valid |-> alloc_slot < 3'd7);
  a_r8_full_stalls_new: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && q_full && alloc_slot == 3'd0) |-> alloc_stall);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ret_groups == '0) && (ren_release == '0));
endmodule

bind retire_group_queue rgq_checker #(
  .QDEPTH(QDEPTH), .RET_W(RET_W), .REN_CAP(REN_CAP), .REN_REL(REN_REL),
  .CNT_W(CNT_W), .REN_W(REN_W), .RC_W(RC_W), .REL_W(REL_W)
) u_rgq_checker (
  .clk(clk), .rst(rst), .flush(flush), .alloc_valid(alloc_valid),
  .alloc_stall(alloc_stall), .q_full(q_full), .alloc_slot(alloc_slot),
  .ret_groups(ret_groups), .ren_release(ren_release), .cnt(cnt_q),
  .ren_used(ren_used)
);

// File: tb/test_retire_group_queue.sv
module test_retire_group_queue;
  localparam int Q  = 5;
  localparam int RW = 2;
  localparam int MI = 4;
  localparam int RC = 12;
  localparam int RR = 3;
  localparam int TAG_W = $clog2(Q);
  localparam int RC_W  = $clog2(RW + 1);
  localparam int REL_W = $clog2(RR + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic av = 0, aff = 0, alf = 0, ais = 0;
  logic [1:0] awr = '0;
  logic cv = 0;
  logic [TAG_W-1:0] ctag = '0;
  logic [2:0] cslot = '0;
  logic fl = 0;
  logic alloc_stall, q_full;
  logic [TAG_W-1:0] alloc_tag;
  logic [2:0] alloc_slot;
  logic [RC_W-1:0] ret_groups;
  logic [REL_W-1:0] ren_release;

  retire_group_queue #(.QDEPTH(Q), .RET_W(RW), .MAX_ISSUE(MI), .REN_CAP(RC), .REN_REL(RR))
  i_retire_group_queue (
    .clk(clk), .rst(rst), .alloc_valid(av), .alloc_fault_first(aff),
    .alloc_fail_last(alf), .alloc_issue(ais), .alloc_writes(awr),
    .alloc_stall(alloc_stall), .alloc_tag(alloc_tag), .alloc_slot(alloc_slot),
    .cpl_valid(cv), .cpl_tag(ctag), .cpl_slot(cslot), .flush(fl),
    .q_full(q_full), .ret_groups(ret_groups), .ren_release(ren_release)
  );

  always #4 clk = ~clk;

  typedef struct {int tag; int n; int iss; int done; bit closed; int wr;} grp_t;
  grp_t g[$];
  int outst[$];
  int next_tag, used, pend, spec, exp_ret, exp_rel;
  int ncmp = 0, nbad = 0, cyc = 0;
  bit first_after_rst;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    ncmp++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int gs, ocnt, oiss, tag_e, slot_e, rel, k, ws;
    bit op, need, full_e, blk, stall_e, acc, idle;
    grp_t ng;
    gs = g.size();
    op = gs > 0 && !g[gs-1].closed;
    ocnt = op ? g[gs-1].n : 0;
    oiss = op ? g[gs-1].iss : 0;
    need = !op || aff || ocnt == 7 || (ais && oiss >= MI);
    full_e = (gs == Q);
    blk = (used + int'(awr)) > RC;
    stall_e = av && ((need && full_e) || blk);
    tag_e = need ? next_tag : g[gs-1].tag;
    slot_e = need ? 0 : ocnt;
    if (first_after_rst) begin
      chk(q_full == 0 && ret_groups == 0 && ren_release == 0, "R1", "reset outputs",
          int'(q_full) + int'(ret_groups) + int'(ren_release), 0);
      first_after_rst = 0;
    end
    chk(q_full == full_e, "R8", "q_full", int'(q_full), int'(full_e));
    chk(alloc_stall == stall_e, "R8/R9", "alloc_stall", int'(alloc_stall), int'(stall_e));
    if (av) begin
      chk(int'(alloc_tag) == tag_e, "R11/R12", "alloc_tag", int'(alloc_tag), tag_e);
      chk(int'(alloc_slot) == slot_e, "R2/R3/R4/R5", "alloc_slot", int'(alloc_slot), slot_e);
    end
    chk(int'(ret_groups) == exp_ret, "R6/R7/R11", "ret_groups", int'(ret_groups), exp_ret);
    chk(int'(ren_release) == exp_rel, "R10", "ren_release", int'(ren_release), exp_rel);
    // next state
    acc = av && !stall_e && !fl;
    rel = (pend < RR) ? pend : RR;
    pend -= rel; used -= rel; exp_rel = rel;
    if (fl) begin
      used -= spec; spec = 0;
      if (gs > 0) next_tag = g[0].tag;
      g.delete(); outst.delete();
      exp_ret = 0;
    end else begin
      k = 0; ws = 0;
      while (k < RW && g.size() > 0 && g[0].closed && g[0].done == ((1 << g[0].n) - 1)) begin
        ws += g[0].wr; void'(g.pop_front()); k++;
      end
      exp_ret = k; pend += ws; spec -= ws;
      gs = g.size();
      idle = op && !av && gs > 0 && g[gs-1].done == ((1 << g[gs-1].n) - 1);
      if (cv) foreach (g[i]) if (g[i].tag == int'(ctag)) g[i].done = g[i].done | (1 << int'(cslot));
      if (idle) g[gs-1].closed = 1;
      if (acc) begin
        if (need) begin
          if (op) g[gs-1].closed = 1;
          ng.tag = next_tag; ng.n = 1; ng.iss = int'(ais); ng.done = 0;
          ng.closed = alf; ng.wr = int'(awr);
          g.push_back(ng);
          next_tag = (next_tag + 1) % Q;
        end else begin
          g[gs-1].n++; g[gs-1].iss += int'(ais); g[gs-1].wr += int'(awr);
          if (alf) g[gs-1].closed = 1;
        end
        used += int'(awr); spec += int'(awr);
        outst.push_back(tag_e * 8 + slot_e);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      g.delete(); outst.delete();
      next_tag = 0; used = 0; pend = 0; spec = 0; exp_ret = 0; exp_rel = 0;
      first_after_rst = 1;
    end else begin
      model_step();
    end
  end

  task automatic drive(bit v, bit ff, bit lf, bit is, int wr, bit c, bit f);
    int idx, e;
    @(posedge clk); #1;
    av = v; aff = ff; alf = lf; ais = is; awr = 2'(wr); fl = f;
    if (c && outst.size() > 0) begin
      idx = int'($urandom % outst.size());
      e = outst[idx]; outst.delete(idx);
      cv = 1; ctag = TAG_W'(e / 8); cslot = 3'(e % 8);
    end else begin
      cv = 0;
    end
  endtask

  task automatic drain(int n);
    repeat (n) drive(0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      ncmp++; nbad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R2: seven plain uops fill a group, the eighth and ninth open the next
    repeat (9) drive(1, 0, 0, 0, 0, 0, 0);
    drain(14);            // R7 idle close then R6 retire
    // R3 and R4 placement
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 1, 1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drain(16);
    // R5 issue limit
    repeat (4) drive(1, 0, 0, 1, 0, 0, 0);
    repeat (2) drive(1, 0, 0, 0, 0, 0, 0);
    repeat (2) drive(1, 0, 0, 1, 0, 0, 0);
    drain(16);
    // R8 queue full, append still accepted
    repeat (7) drive(1, 1, 0, 0, 0, 0, 0);
    repeat (2) drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0, 0);
    drain(20);
    // R9 write limit
    repeat (9) drive(1, 0, 0, 0, 2, 0, 0);
    drain(20);
    // R6 retire width and R10 release rate
    repeat (24) drive(1, 0, 1, 0, 3, 1, 0);
    drain(24);
    // R11 flush mid stream
    repeat (6) drive(1, 0, 0, 1, 1, 0, 0);
    drive(1, 1, 0, 0, 2, 1, 0);
    drive(1, 0, 0, 0, 1, 1, 0);
    drive(1, 0, 0, 0, 1, 1, 1);
    repeat (4) drive(1, 0, 0, 0, 1, 0, 0);
    drain(20);
    // mixed traffic with occasional flush
    for (int i = 0; i < 4000; i++) begin
      drive($urandom % 4 != 0, $urandom % 5 == 0, $urandom % 5 == 0, $urandom % 2 == 1,
            int'($urandom % 4), $urandom % 3 != 0, $urandom % 250 == 0);
    end
    drain(60);
    finish_run();
  end
endmodule